// File: doc/BRIEF.md
# Half-Cycle Synchronized Energy Accumulator

This block sums a stream of signed active-power samples over a window whose length is a whole number of half line cycles. The voltage channel arrives as a separate stream of signed samples. Every change of polarity on that stream counts as one half cycle. A small deadband around zero stops noise from producing false crossings. When the programmed number of crossings has been seen, the running sum is copied into a 40-bit signed result register, the accumulator restarts from zero in the same cycle, and the next window begins at once.

Accumulation runs only while the mode input is high. The first window after the mode is raised starts at an arbitrary point of the line cycle, so its result is marked invalid. Every later window is marked valid. Completion sets a sticky status flag that the host clears by writing one to a clear strobe. When the interrupt enable is high, the flag also pulls an active-low interrupt line low.

Top module: `halfcyc_energy_acc`

## Requirements
- R1: While `mode_en` is low, no window completes, `done_flag` is not set by crossings, `result` keeps its value and the running sum is cleared.
- R2: A voltage sample above +16 is positive and one below -16 is negative. A sample whose magnitude is 16 or less is ignored. A crossing is a valid sample whose polarity is opposite to that of the last sample outside the deadband.
- R3: With `mode_en` high, a window ends on the crossing that brings its count to `half_cycles`. A value of 0 is treated as 1. `result` then holds the sum of every valid power sample from the cycle after the previous window end through the ending cycle, inclusive.
- R4: The sum wraps in 40-bit two's complement when it overflows.
- R5: `done_flag` rises on the clock edge that ends a window and stays high until a cycle with `clr_done` high. If a window ends in the same cycle as a clear, the flag stays set.
- R6: `irq_n` is low exactly when `done_flag` and `irq_en` are both high.
- R7: While `mode_en` stays high, windows follow one another with no gap and no host action.
- R8: `result_valid` is 0 after the first window that follows a rise of `mode_en`, and 1 after each later window.
- R9: After reset, `result` is 0, `result_valid` is 0, `done_flag` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_valid | input | 1 | Power sample strobe |
| pwr_sample | input | 24 | Signed active-power sample |
| volt_valid | input | 1 | Voltage sample strobe |
| volt_sample | input | 24 | Signed voltage sample |
| mode_en | input | 1 | Enables windowed accumulation |
| half_cycles | input | 14 | Window length in half cycles (0 acts as 1) |
| irq_en | input | 1 | Interrupt enable |
| clr_done | input | 1 | Write-one-to-clear strobe for the status flag |
| result | output | 40 | Signed sum of the last completed window |
| result_valid | output | 1 | Last result came from a synchronized window |
| done_flag | output | 1 | Sticky window-complete flag |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two functions can land in the same cycle: a window end that sets the status flag, and a host clear of that same flag. The bench sets up a one-half-cycle window. It drives the ending crossing and `clr_done` high in one cycle, then checks on the next cycle that the flag is still set and that the result holds exactly the single sample of that cycle. A later clear on its own is checked to drop the flag.

// File: rtl/halfcyc_pkg.sv
package halfcyc_pkg;
    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_e;
endpackage

// File: rtl/hc_zero_cross.sv
module hc_zero_cross
    import halfcyc_pkg::*;
#(
    parameter int VW = 24,
    parameter int DB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          volt_valid,
    input  logic [VW-1:0] volt_sample,
    output logic          crossing
);
    localparam logic signed [VW-1:0] DB_HI = VW'(DB);
    localparam logic signed [VW-1:0] DB_LO = -VW'(DB);

    typedef struct packed {
        pol_e pol;
    } zc_state_t;

    zc_state_t st_d, st_q;
    pol_e      sample_pol;

    always_comb begin
        st_d       = st_q;
        sample_pol = POL_NONE;
        if ($signed(volt_sample) > DB_HI) begin
            sample_pol = POL_POS;
        end else if ($signed(volt_sample) < DB_LO) begin
            sample_pol = POL_NEG;
        end
        crossing = volt_valid && (st_q.pol != POL_NONE) &&
                   (sample_pol != POL_NONE) && (sample_pol != st_q.pol);
        if (volt_valid && sample_pol != POL_NONE) begin
            st_d.pol = sample_pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pol: POL_NONE};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hc_window_ctrl.sv
module hc_window_ctrl #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          crossing,
    input  logic [CW-1:0] half_cycles,
    output logic          win_end,
    output logic          first_win
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          first;
    } win_state_t;

    win_state_t  st_d, st_q;
    logic [CW:0] eff_n;
    logic [CW:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        eff_n    = (half_cycles == '0) ? (CW+1)'(1) : {1'b0, half_cycles};
        cnt_next = {1'b0, st_q.cnt} + (CW+1)'(1);
        win_end  = mode_en && crossing && (cnt_next >= eff_n);
        if (!mode_en) begin
            st_d.cnt   = '0;
            st_d.first = 1'b1;
        end else if (win_end) begin
            st_d.cnt   = '0;
            st_d.first = 1'b0;
        end else if (crossing) begin
            st_d.cnt   = cnt_next[CW-1:0];
        end
    end

    assign first_win = st_q.first;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, first: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hc_accum.sv
module hc_accum #(
    parameter int PW = 24,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          pwr_valid,
    input  logic [PW-1:0] pwr_sample,
    input  logic          win_end,
    input  logic          first_win,
    output logic [AW-1:0] result,
    output logic          result_valid
);
    typedef struct packed {
        logic [AW-1:0] acc;
        logic [AW-1:0] res;
        logic          res_ok;
    } acc_state_t;

    acc_state_t    st_d, st_q;
    logic [AW-1:0] addend;
    logic [AW-1:0] sum;

    always_comb begin
        st_d   = st_q;
        addend = pwr_valid ? {{(AW-PW){pwr_sample[PW-1]}}, pwr_sample} : '0;
        sum    = st_q.acc + addend;
        if (!mode_en) begin
            st_d.acc = '0;
        end else if (win_end) begin
            st_d.res    = sum;
            st_d.res_ok = !first_win;
            st_d.acc    = '0;
        end else begin
            st_d.acc = sum;
        end
    end

    assign result       = st_q.res;
    assign result_valid = st_q.res_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '0, res: '0, res_ok: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/halfcyc_energy_acc.sv
module halfcyc_energy_acc #(
    parameter int PW = 24,
    parameter int VW = 24,
    parameter int AW = 40,
    parameter int CW = 14,
    parameter int DB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_valid,
    input  logic [PW-1:0] pwr_sample,
    input  logic          volt_valid,
    input  logic [VW-1:0] volt_sample,
    input  logic          mode_en,
    input  logic [CW-1:0] half_cycles,
    input  logic          irq_en,
    input  logic          clr_done,
    output logic [AW-1:0] result,
    output logic          result_valid,
    output logic          done_flag,
    output logic          irq_n
);
    logic crossing;
    logic win_end;
    logic first_win;
    logic done_d, done_q;

    hc_zero_cross #(.VW(VW), .DB(DB)) zc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .volt_valid  (volt_valid),
        .volt_sample (volt_sample),
        .crossing    (crossing)
    );

    hc_window_ctrl #(.CW(CW)) win_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_en     (mode_en),
        .crossing    (crossing),
        .half_cycles (half_cycles),
        .win_end     (win_end),
        .first_win   (first_win)
    );

    hc_accum #(.PW(PW), .AW(AW)) acc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_en      (mode_en),
        .pwr_valid    (pwr_valid),
        .pwr_sample   (pwr_sample),
        .win_end      (win_end),
        .first_win    (first_win),
        .result       (result),
        .result_valid (result_valid)
    );

    // set has priority over a same-cycle clear
    always_comb begin
        done_d = (done_q && !clr_done) || win_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done_flag = done_q;
    assign irq_n     = !(done_q && irq_en);
endmodule

// File: rtl/halfcyc_energy_acc_chk.sv
module halfcyc_energy_acc_chk #(
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en,
    input logic          irq_en,
    input logic          clr_done,
    input logic [AW-1:0] result,
    input logic          result_valid,
    input logic          done_flag,
    input logic          irq_n
);
    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> $stable(result));

    assert_clear_only_by_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(clr_done));

    assert_set_needs_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(mode_en));

    assert_valid_moves_in_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_valid) |-> $past(mode_en));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (done_flag && irq_en));
endmodule

bind halfcyc_energy_acc halfcyc_energy_acc_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_en      (mode_en),
    .irq_en       (irq_en),
    .clr_done     (clr_done),
    .result       (result),
    .result_valid (result_valid),
    .done_flag    (done_flag),
    .irq_n        (irq_n)
);

// File: tb/halfcyc_energy_acc_tb_top.sv
`timescale 1ns/1ps
module halfcyc_energy_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_valid = 1'b0;
    logic [23:0] pwr_sample = '0;
    logic        volt_valid = 1'b0;
    logic [23:0] volt_sample = '0;
    logic        mode_en = 1'b0;
    logic [13:0] half_cycles = '0;
    logic        irq_en = 1'b0;
    logic        clr_done = 1'b0;
    logic [39:0] result;
    logic        result_valid;
    logic        done_flag;
    logic        irq_n;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    halfcyc_energy_acc dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_sample(pwr_sample),
        .volt_valid(volt_valid), .volt_sample(volt_sample), .mode_en(mode_en),
        .half_cycles(half_cycles), .irq_en(irq_en), .clr_done(clr_done),
        .result(result), .result_valid(result_valid), .done_flag(done_flag),
        .irq_n(irq_n)
    );

    // vector: {half_cycles[13:0], power[23:0], gap[15:0]}
    localparam int NV = 5;
    localparam logic [53:0] VEC [NV] = '{
        {14'd1, 24'sd100,    16'd4},
        {14'd3, -24'sd7,     16'd5},
        {14'd0, 24'sd55,     16'd6},
        {14'd4, 24'h7FFFFF,  16'd3},
        {14'd2, 24'h7FFFFF,  16'd32770}
    };

    localparam logic [23:0] VPOS = 24'd1000;
    localparam logic [23:0] VNEG = -24'sd1000;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [23:0] p, input logic [23:0] v, input bit clr);
        pwr_valid = 1'b1; pwr_sample = p;
        volt_valid = 1'b1; volt_sample = v;
        clr_done = clr;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(result == '0, "R9 result", 64'(result), 0);
        check(result_valid == 1'b0, "R9 result_valid", 64'(result_valid), 0);
        check(done_flag == 1'b0, "R9 done_flag", 64'(done_flag), 0);
        check(irq_n == 1'b1, "R9 irq_n", 64'(irq_n), 1);
        rst_n = 1'b1;

        // table: first window invalid, second exact (R3, R4, R7, R8)
        for (int i = 0; i < NV; i++) begin
            logic [13:0] n;
            logic signed [23:0] p;
            int gap;
            int seen;
            int c;
            bit pos;
            logic signed [63:0] e;
            n = VEC[i][53:40]; p = VEC[i][39:16]; gap = int'(VEC[i][15:0]);
            @(negedge clk);
            mode_en = 1'b0; clr_done = 1'b1; pwr_valid = 1'b0;
            volt_valid = 1'b1; volt_sample = VPOS;
            @(negedge clk);
            clr_done = 1'b0; half_cycles = n; mode_en = 1'b1; volt_valid = 1'b0;
            seen = 0; c = 0; pos = 1'b1;
            e = 64'(p) * 64'((n == 0) ? 1 : n) * 64'(gap);
            while (seen < 2) begin
                bit clr;
                @(negedge clk);
                clr = 1'b0;
                if (done_flag) begin
                    seen++;
                    clr = 1'b1;
                    if (seen == 1) begin
                        check(result_valid == 1'b0, "R8 first window invalid",
                              64'(result_valid), 0);
                    end else begin
                        check(result == e[39:0], "R3/R4 window sum", 64'(result), 64'(e[39:0]));
                        check(result_valid == 1'b1, "R7/R8 next window valid",
                              64'(result_valid), 1);
                    end
                end
                c++;
                if (c == gap) begin
                    c = 0; pos = !pos;
                end
                drive(p, pos ? VPOS : VNEG, clr);
            end
        end

        // R5 sticky, R6 interrupt
        @(negedge clk);
        mode_en = 1'b0; pwr_valid = 1'b0; volt_valid = 1'b0; clr_done = 1'b0;
        repeat (3) @(negedge clk);
        check(done_flag == 1'b0, "R5 cleared by host", 64'(done_flag), 0);
        mode_en = 1'b1; half_cycles = 14'd1;
        drive(24'd1, VPOS, 1'b0);
        @(negedge clk);
        drive(24'd1, VNEG, 1'b0);
        @(negedge clk);
        mode_en = 1'b0; volt_valid = 1'b0; pwr_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(done_flag == 1'b1, "R5 sticky", 64'(done_flag), 1);
        check(irq_n == 1'b1, "R6 irq masked", 64'(irq_n), 1);
        irq_en = 1'b1;
        #1;
        check(irq_n == 1'b0, "R6 irq asserted", 64'(irq_n), 0);
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        check(done_flag == 1'b0, "R5 clear", 64'(done_flag), 0);
        check(irq_n == 1'b1, "R6 irq released", 64'(irq_n), 1);

        // R1 mode off: crossings do nothing, result held
        begin
            logic [39:0] held;
            held = result;
            for (int k = 0; k < 8; k++) begin
                drive(24'd500, k[0] ? VPOS : VNEG, 1'b0);
                @(negedge clk);
            end
            check(done_flag == 1'b0, "R1 no window when off", 64'(done_flag), 0);
            check(result == held, "R1 result held", 64'(result), 64'(held));
        end

        // R2 deadband, then R5 set/clear collision
        drive(24'd3, VPOS, 1'b0);
        @(negedge clk);
        mode_en = 1'b1; half_cycles = 14'd1;
        for (int k = 0; k < 6; k++) begin
            drive(24'd3, k[0] ? 24'd5 : -24'sd16, 1'b0);
            @(negedge clk);
        end
        check(done_flag == 1'b0, "R2 deadband ignored", 64'(done_flag), 0);
        drive(24'd3, -24'sd17, 1'b0);
        @(negedge clk);
        check(done_flag == 1'b1, "R2 crossing past deadband", 64'(done_flag), 1);
        check(result_valid == 1'b0, "R8 first after enable", 64'(result_valid), 0);
        drive(24'd3, 24'd17, 1'b1);
        @(negedge clk);
        check(done_flag == 1'b1, "R5 set wins over clear", 64'(done_flag), 1);
        check(result == 40'd3, "R3 one-sample window", 64'(result), 3);
        check(result_valid == 1'b1, "R8 second valid", 64'(result_valid), 1);
        drive(24'd3, 24'd17, 1'b1);
        @(negedge clk);
        clr_done = 1'b0;
        check(done_flag == 1'b0, "R5 clear after collision", 64'(done_flag), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule